// File: doc/BRIEF.md
# USB Host Split-Transaction Channel Sequencer

This block steers one host channel through a split transaction. A high-speed host uses split transactions to reach a full- or low-speed device that sits behind a hub. Software writes a control word that enables the channel and names the transfer kind. The channel then gets ready for the start split. For outbound kinds it first pulls the packet words in. For interrupt OUT it also waits for the frame parity that software chose. It then asks the shared request arbiter for a slot. On a grant it posts the start-split request for one cycle and drops out of arbitration.

Once the start split has gone out, the channel halts and raises a sticky halted interrupt. It does nothing more until software clears the interrupt and re-enables the channel with the complete-split flag set. The channel then competes for a new grant and posts the complete-split request. It halts a second time when that phase is done. For an inbound transfer, that means when the received data has been written to memory. For an outbound transfer, it means when the token has been sent. Packet encoding, DMA, FIFOs and the PHY are outside the block. They appear only as abstract word, token-done and data-done strobes.

Top module: `usb_split_chan`

## Requirements
- R1: After reset the phase output is 0 (idle), and `arb_req`, `req_push`, `fetch_active` and `irq_halt` are all 0.
- R2: The phase output uses this encoding: 0 idle, 1 start-split waiting for grant, 2 start split active, 3 halted after start split, 4 complete-split waiting for grant, 5 complete split active, 6 halted after complete split.
- R3: A control write with `ctl_en`=1 and `ctl_csplit`=0 in phase 0 moves the channel to phase 1. The transfer code is 0 for bulk/control OUT or SETUP, 1 for bulk/control IN and 2 for interrupt OUT. Code 3 is reserved, and an enable that carries it leaves the phase at 0.
- R4: For codes 0 and 2, `fetch_active` is 1 in phase 1 until a word arrives with `dma_last`=1. `arb_req` stays 0 until the cycle after that word. For code 1, `arb_req` is 1 as soon as phase 1 is entered.
- R5: For code 2 in phase 1, `arb_req` is 1 only while `frame_odd` equals the odd-frame bit written with the enable.
- R6: When `arb_req` and `arb_gnt` are both 1, `req_push` is 1 in the same cycle. `req_csplit` is 0 in phase 1 and 1 in phase 4. `req_dir_in` is 1 only for code 1. The next cycle is in phase 2 or 5, and `arb_req` is 0 there.
- R7: In phase 2, `token_done` moves the channel to phase 3 on the next cycle. No further request is raised from phase 3 without a software write.
- R8: In phase 5, code 1 halts to phase 6 only on `data_done` and ignores `token_done`. Codes 0 and 2 halt on `token_done`.
- R9: `irq_halt` goes to 1 on the cycle a halted phase (3 or 6) is entered. It stays 1 until an `irq_clr` pulse, and it is set once per phase completion.
- R10: A control write with `ctl_en`=1 and `ctl_csplit`=1 in phase 3 moves the channel to phase 4, but only while `irq_halt` is 0. While the interrupt is pending, any enable is ignored and the phase does not change.
- R11: A control write with `ctl_en`=0 returns the channel to phase 0 from any phase. `arb_req` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_en | input | 1 | Channel enable bit of the write |
| ctl_csplit | input | 1 | Complete-split flag of the write |
| ctl_xfer | input | 2 | Transfer kind code |
| ctl_odd | input | 1 | Frame parity wanted for interrupt OUT |
| irq_clr | input | 1 | Write-one-to-clear for the halted interrupt |
| frame_odd | input | 1 | Parity of the current frame or micro-frame |
| dma_valid | input | 1 | A packet word has been fetched |
| dma_last | input | 1 | The fetched word is the final one |
| arb_gnt | input | 1 | Grant from the request arbiter |
| token_done | input | 1 | Token of the active phase has been sent |
| data_done | input | 1 | Received packet has been written to memory |
| arb_req | output | 1 | Request toward the arbiter |
| req_push | output | 1 | One-cycle post of a request into the queue |
| req_csplit | output | 1 | Posted request is a complete split |
| req_dir_in | output | 1 | Posted request is inbound |
| fetch_active | output | 1 | Channel is fetching outbound packet words |
| irq_halt | output | 1 | Sticky channel-halted interrupt |
| phase | output | 3 | Current phase code |

## Verification
Each transfer kind is driven through both split phases. Grant latency is random, and the frame parity is random. Inbound and outbound channels are then told apart by which strobe ends the complete phase: a stray `token_done` must not halt an inbound channel. Interrupt OUT runs first hold the frame parity opposite to the chosen bit, which shows that the parity gate blocks the request. Directed cases try a re-enable while the interrupt is pending, the reserved transfer code, and disabling in the middle of a phase. These show that ignored writes leave the phase unchanged and that disabling clears the request.

// File: rtl/usb_split_pkg.sv
package usb_split_pkg;
  localparam int PHASE_W = 3;
  localparam int XFER_W  = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE    = 3'd0,
    PH_SS_WAIT = 3'd1,
    PH_SS_ACT  = 3'd2,
    PH_SS_HALT = 3'd3,
    PH_CS_WAIT = 3'd4,
    PH_CS_ACT  = 3'd5,
    PH_CS_HALT = 3'd6
  } phase_e;

  typedef enum logic [XFER_W-1:0] {
    XF_BULK_OUT = 2'd0,
    XF_BULK_IN  = 2'd1,
    XF_INTR_OUT = 2'd2,
    XF_RSVD     = 2'd3
  } xfer_e;

  function automatic logic xfer_is_out(input logic [XFER_W-1:0] x);
    return (x == XF_BULK_OUT) || (x == XF_INTR_OUT);
  endfunction

  function automatic logic xfer_legal(input logic [XFER_W-1:0] x);
    return x != XF_RSVD;
  endfunction

  function automatic logic parity_ok(input logic [XFER_W-1:0] x,
                                     input logic want_odd,
                                     input logic cur_odd);
    return (x != XF_INTR_OUT) || (want_odd == cur_odd);
  endfunction

  function automatic logic cs_ends_on_data(input logic [XFER_W-1:0] x);
    return x == XF_BULK_IN;
  endfunction
endpackage

// File: rtl/split_halt_irq.sv
module split_halt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/split_fetch_gate.sv
module split_fetch_gate
  import usb_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_ss_wait_i,
  input  logic [XFER_W-1:0] xfer_i,
  input  logic              want_odd_i,
  input  logic              frame_odd_i,
  input  logic              dma_valid_i,
  input  logic              dma_last_i,
  output logic              fetch_active_o,
  output logic              ss_ready_o
);
  logic fetched_q;
  logic is_out;

  assign is_out = xfer_is_out(xfer_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fetched_q <= 1'b0;
    else if (!in_ss_wait_i)
      fetched_q <= 1'b0;
    else if (is_out && dma_valid_i && dma_last_i)
      fetched_q <= 1'b1;
  end

  assign fetch_active_o = in_ss_wait_i && is_out && !fetched_q;
  assign ss_ready_o     = in_ss_wait_i
                        && parity_ok(xfer_i, want_odd_i, frame_odd_i)
                        && (!is_out || fetched_q);
endmodule

// File: rtl/split_phase_fsm.sv
module split_phase_fsm
  import usb_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_i,
  input  logic              ctl_en_i,
  input  logic              ctl_csplit_i,
  input  logic [XFER_W-1:0] ctl_xfer_i,
  input  logic              ctl_odd_i,
  input  logic              irq_pend_i,
  input  logic              ss_ready_i,
  input  logic              arb_gnt_i,
  input  logic              token_done_i,
  input  logic              data_done_i,
  output phase_e            phase_o,
  output logic [XFER_W-1:0] cfg_xfer_o,
  output logic              cfg_odd_o,
  output logic              arb_req_o,
  output logic              req_push_o,
  output logic              req_csplit_o,
  output logic              halt_evt_o
);
  phase_e ph_q, ph_d;
  logic   start_ok, csplit_ok, disable_wr, cs_done;

  assign disable_wr = ctl_wr_i && !ctl_en_i;
  assign start_ok   = ctl_wr_i && ctl_en_i && !ctl_csplit_i && !irq_pend_i
                    && xfer_legal(ctl_xfer_i);
  assign csplit_ok  = ctl_wr_i && ctl_en_i && ctl_csplit_i && !irq_pend_i;
  assign cs_done    = cs_ends_on_data(cfg_xfer_o) ? data_done_i : token_done_i;

  assign arb_req_o    = ((ph_q == PH_SS_WAIT) && ss_ready_i) || (ph_q == PH_CS_WAIT);
  assign req_push_o   = arb_req_o && arb_gnt_i;
  assign req_csplit_o = (ph_q == PH_CS_WAIT);

  always_comb begin
    ph_d = ph_q;
    if (disable_wr) begin
      ph_d = PH_IDLE;
    end else begin
      unique case (ph_q)
        PH_IDLE:    if (start_ok)     ph_d = PH_SS_WAIT;
        PH_SS_WAIT: if (req_push_o)   ph_d = PH_SS_ACT;
        PH_SS_ACT:  if (token_done_i) ph_d = PH_SS_HALT;
        PH_SS_HALT: if (csplit_ok)    ph_d = PH_CS_WAIT;
        PH_CS_WAIT: if (req_push_o)   ph_d = PH_CS_ACT;
        PH_CS_ACT:  if (cs_done)      ph_d = PH_CS_HALT;
        PH_CS_HALT: ph_d = PH_CS_HALT;
        default:    ph_d = PH_IDLE;
      endcase
    end
  end

  assign halt_evt_o = ((ph_q == PH_SS_ACT) && (ph_d == PH_SS_HALT))
                   || ((ph_q == PH_CS_ACT) && (ph_d == PH_CS_HALT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cfg_xfer_o <= '0;
      cfg_odd_o  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if ((ph_q == PH_IDLE) && start_ok && !disable_wr) begin
        cfg_xfer_o <= ctl_xfer_i;
        cfg_odd_o  <= ctl_odd_i;
      end
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/usb_split_chan.sv
module usb_split_chan
  import usb_split_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_en,
  input  logic              ctl_csplit,
  input  logic [XFER_W-1:0] ctl_xfer,
  input  logic              ctl_odd,
  input  logic              irq_clr,
  input  logic              frame_odd,
  input  logic              dma_valid,
  input  logic              dma_last,
  input  logic              arb_gnt,
  input  logic              token_done,
  input  logic              data_done,
  output logic              arb_req,
  output logic              req_push,
  output logic              req_csplit,
  output logic              req_dir_in,
  output logic              fetch_active,
  output logic              irq_halt,
  output logic [PHASE_W-1:0] phase
);
  phase_e            ph;
  logic [XFER_W-1:0] cfg_xfer;
  logic              cfg_odd;
  logic              ss_ready;
  logic              halt_evt;
  logic              in_ss_wait;

  assign in_ss_wait = (ph == PH_SS_WAIT);

  split_fetch_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ss_wait_i   (in_ss_wait),
    .xfer_i         (cfg_xfer),
    .want_odd_i     (cfg_odd),
    .frame_odd_i    (frame_odd),
    .dma_valid_i    (dma_valid),
    .dma_last_i     (dma_last),
    .fetch_active_o (fetch_active),
    .ss_ready_o     (ss_ready)
  );

  split_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr_i     (ctl_wr),
    .ctl_en_i     (ctl_en),
    .ctl_csplit_i (ctl_csplit),
    .ctl_xfer_i   (ctl_xfer),
    .ctl_odd_i    (ctl_odd),
    .irq_pend_i   (irq_halt),
    .ss_ready_i   (ss_ready),
    .arb_gnt_i    (arb_gnt),
    .token_done_i (token_done),
    .data_done_i  (data_done),
    .phase_o      (ph),
    .cfg_xfer_o   (cfg_xfer),
    .cfg_odd_o    (cfg_odd),
    .arb_req_o    (arb_req),
    .req_push_o   (req_push),
    .req_csplit_o (req_csplit),
    .halt_evt_o   (halt_evt)
  );

  split_halt_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (halt_evt),
    .clr_i  (irq_clr),
    .pend_o (irq_halt)
  );

  assign req_dir_in = (cfg_xfer == XF_BULK_IN);
  assign phase      = ph;
endmodule

// File: rtl/split_chan_checker.sv
module split_chan_checker
  import usb_split_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              ctl_en,
  input logic              irq_clr,
  input logic              frame_odd,
  input logic              arb_gnt,
  input logic              arb_req,
  input logic              req_push,
  input logic              irq_halt,
  input logic              halt_evt,
  input logic [PHASE_W-1:0] phase,
  input logic [XFER_W-1:0] cfg_xfer,
  input logic              cfg_odd
);
  assert_push_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_push |-> (arb_gnt && arb_req));

  assert_masked_after_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_push |=> !arb_req);

  assert_parity_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && phase == 3'd1 && cfg_xfer == 2'd2) |-> (frame_odd == cfg_odd));

  assert_halt_sets_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> irq_halt);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_halt && !irq_clr) |=> irq_halt);

  assert_halted_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 || phase == 3'd6) |-> !arb_req);

  assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_en) |=> (phase == 3'd0));

  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 3'd7);
endmodule

bind usb_split_chan split_chan_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_en    (ctl_en),
  .irq_clr   (irq_clr),
  .frame_odd (frame_odd),
  .arb_gnt   (arb_gnt),
  .arb_req   (arb_req),
  .req_push  (req_push),
  .irq_halt  (irq_halt),
  .halt_evt  (halt_evt),
  .phase     (phase),
  .cfg_xfer  (cfg_xfer),
  .cfg_odd   (cfg_odd)
);

// File: tb/sim_usb_split_chan.sv
module sim_usb_split_chan;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_en = 0, ctl_csplit = 0, ctl_odd = 0;
  logic [1:0] ctl_xfer = 0;
  logic irq_clr = 0, frame_odd = 0, dma_valid = 0, dma_last = 0;
  logic arb_gnt = 0, token_done = 0, data_done = 0;
  logic arb_req, req_push, req_csplit, req_dir_in, fetch_active, irq_halt;
  logic [2:0] phase;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_split_chan u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_csplit(ctl_csplit), .ctl_xfer(ctl_xfer), .ctl_odd(ctl_odd),
    .irq_clr(irq_clr), .frame_odd(frame_odd), .dma_valid(dma_valid),
    .dma_last(dma_last), .arb_gnt(arb_gnt), .token_done(token_done),
    .data_done(data_done), .arb_req(arb_req), .req_push(req_push),
    .req_csplit(req_csplit), .req_dir_in(req_dir_in),
    .fetch_active(fetch_active), .irq_halt(irq_halt), .phase(phase)
  );

  function automatic bit exp_out(input int x);
    return (x == 0) || (x == 2);
  endfunction

  function automatic bit exp_cs_data(input int x);
    return x == 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input bit en, input bit cs, input int x, input bit odd);
    ctl_wr = 1; ctl_en = en; ctl_csplit = cs; ctl_xfer = 2'(x); ctl_odd = odd;
    tick;
    ctl_wr = 0; ctl_en = 0; ctl_csplit = 0;
  endtask

  task automatic clr_irq;
    irq_clr = 1; tick; irq_clr = 0;
  endtask

  task automatic grant(input bit cs, input int x);
    arb_gnt = 1; #1;
    eq("R6 push", int'(req_push), 1);
    eq("R6 csplit", int'(req_csplit), int'(cs));
    eq("R6 dir", int'(req_dir_in), int'(x == 1));
    tick;
    arb_gnt = 0;
    eq("R6 masked", int'(arb_req), 0);
    eq("R2 active phase", int'(phase), cs ? 5 : 2);
  endtask

  task automatic run_txn(input int x, input bit odd, input int lat);
    frame_odd = (x == 2) ? ~odd : 1'($urandom % 2);
    wr(1, 0, x, odd);
    eq("R3 enter ss wait", int'(phase), 1);
    if (exp_out(x)) begin
      eq("R4 fetch active", int'(fetch_active), 1);
      eq("R4 no req before fetch", int'(arb_req), 0);
      for (int w = 0; w < 3; w++) begin
        dma_valid = 1; dma_last = (w == 2);
        tick;
      end
      dma_valid = 0; dma_last = 0;
      eq("R4 fetch done", int'(fetch_active), 0);
    end
    if (x == 2) begin
      #1 eq("R5 parity blocks", int'(arb_req), 0);
      tick;
      frame_odd = odd;
    end
    #1 eq("R4 req raised", int'(arb_req), 1);
    for (int i = 0; i < lat; i++) begin
      tick;
      eq("R6 no push without grant", int'(req_push), 0);
    end
    grant(0, x);
    token_done = 1; tick; token_done = 0;
    eq("R7 halted ss", int'(phase), 3);
    eq("R9 irq set", int'(irq_halt), 1);
    wr(1, 1, x, odd);
    eq("R10 ignored while pending", int'(phase), 3);
    tick;
    eq("R9 irq sticky", int'(irq_halt), 1);
    eq("R7 no own csplit", int'(arb_req), 0);
    clr_irq;
    eq("R9 irq cleared", int'(irq_halt), 0);
    wr(1, 1, x, odd);
    eq("R10 csplit accepted", int'(phase), 4);
    eq("R6 cs req", int'(arb_req), 1);
    grant(1, x);
    if (exp_cs_data(x)) begin
      token_done = 1; tick; token_done = 0;
      eq("R8 in ignores token", int'(phase), 5);
      data_done = 1; tick; data_done = 0;
    end else begin
      token_done = 1; tick; token_done = 0;
    end
    eq("R8 halted done", int'(phase), 6);
    eq("R9 irq again", int'(irq_halt), 1);
    wr(0, 0, 0, 0);
    eq("R11 back to idle", int'(phase), 0);
    clr_irq;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    repeat (3) @(posedge clk);
    #2;
    eq("R1 phase", int'(phase), 0);
    eq("R1 arb_req", int'(arb_req), 0);
    eq("R1 irq", int'(irq_halt), 0);
    eq("R1 fetch", int'(fetch_active), 0);
    rst_n = 1;
    tick;
    eq("R1 after release", int'(phase), 0);
    run_txn(0, 0, 0);
    run_txn(1, 1, 2);
    run_txn(2, 1, 1);
    run_txn(2, 0, 3);
    wr(1, 0, 3, 0);
    eq("R3 reserved code ignored", int'(phase), 0);
    wr(1, 0, 1, 0);
    eq("R3 in enable", int'(phase), 1);
    wr(0, 0, 0, 0);
    eq("R11 disable in wait", int'(phase), 0);
    eq("R11 req cleared", int'(arb_req), 0);
    wr(1, 0, 1, 0);
    grant(0, 1);
    wr(0, 0, 0, 0);
    eq("R11 disable in active", int'(phase), 0);
    token_done = 1; tick; token_done = 0;
    eq("R9 no irq after disable", int'(irq_halt), 0);
    for (int k = 0; k < 40; k++)
      run_txn(int'($urandom % 3), 1'($urandom % 2), int'($urandom % 4));
    finish_up;
  end
endmodule